// File: doc/BRIEF.md
# Memory Controller Local Request Front-End

This block sits between user logic and the command scheduler of a DDR-style memory controller. The user presents read or write requests. Each request carries an address, a chip select and a local burst size. A request is taken in any cycle where both its valid and the block's ready are high. Legal requests go into a four-entry queue, which is offered to the scheduler through a valid/ready port in arrival order. Requests to different chip selects share the same queue.

For every accepted write, the block asks the user for data one local beat at a time, with one pulse per beat. Writes are served in acceptance order, and their pulses may run back to back. The user drives write data and byte enables in the cycle after each pulse. The block forwards them with a valid strobe. The block checks the burst size against the device burst length: the limit is half the device burst length, or at most 2 in DDR2 mode. A request with an illegal size is consumed and flagged, and it is never queued.

Top module: `mem_req_frontend`

## Requirements
- R1: A request with a legal size is accepted on a rising edge where `req_valid` and `req_ready` are both high. It then appears at the command port with the same write flag, address, chip select and size. A new request may be accepted on the very next edge.
- R2: The command port presents queued requests in acceptance order. `cmd_valid` is high whenever at least one entry is queued. An entry leaves on an edge where `cmd_valid` and `cmd_ready` are both high. While it is stalled, its fields stay unchanged.
- R3: No more than four requests are ever queued. With `cmd_ready` held low, four accepted requests (mixed chip selects allowed) leave `req_ready` low, and a fifth request is not taken.
- R4: `req_ready` is low while four entries are queued, or while four accepted writes still await data pulses. It is high otherwise. Ready therefore falls in the cycle after the fourth entry is accepted, and it rises in the cycle after an entry drains.
- R5: A size is legal when it lies between 1 and DEV_BL/2 inclusive. With `DDR2_MODE`=1, the upper bound is also capped at 2. With DEV_BL=8 this allows 1..4 normally and 1..2 in DDR2 mode.
- R6: Size 0 or a size above the limit, presented while `req_ready` is high, raises `req_err` in that same cycle. The request is consumed and not queued.
- R7: Each accepted write of size N produces exactly N `wdata_req` pulse cycles. The first comes in the cycle after acceptance if no earlier write is still waiting. Writes are served in acceptance order with no gap between them.
- R8: `wd_valid` is high exactly in the cycle after each `wdata_req` cycle. During it, `wd_data` and `wd_be` equal `wdata_in` and `wbe_in`.
- R9: Read requests never produce a `wdata_req` pulse.
- R10: Synchronous reset (`rst` high on an edge) empties the queue and cancels pending data pulses. After it, `req_ready` is high and `cmd_valid`, `wdata_req` and `wd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | User request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_cs | input | CS_W | Chip select |
| req_size | input | SIZE_W | Local burst size in beats |
| req_ready | output | 1 | Block can take a request |
| req_err | output | 1 | Current request has an illegal size and is dropped |
| wdata_req | output | 1 | Write data wanted next cycle |
| wdata_in | input | DATA_W | User write data |
| wbe_in | input | DATA_W/8 | User byte enables |
| wd_valid | output | 1 | Forwarded write beat valid |
| wd_data | output | DATA_W | Forwarded write data |
| wd_be | output | DATA_W/8 | Forwarded byte enables |
| cmd_valid | output | 1 | Queue head valid |
| cmd_ready | input | 1 | Scheduler takes the head |
| cmd_write | output | 1 | Head write flag |
| cmd_addr | output | ADDR_W | Head address |
| cmd_cs | output | CS_W | Head chip select |
| cmd_size | output | SIZE_W | Head local size |

## Verification
The bench first fills the queue with mixed chip selects while the scheduler stalls. A design that compares against the wrong depth would take a fifth request or lower ready one entry early. It then drains a single entry and checks that ready returns one cycle later, not two. Back-to-back writes of sizes 2 and 3 must give five contiguous pulses; an off-by-one beat counter would add a pulse or leave a gap. It also sweeps sizes 0 through 7 in both burst modes, so a wrong bound either queues an illegal burst or rejects a legal one. A reset while data pulses are still pending must stop them at once. Long random traffic, with holds respected and cmd_ready random, then compares every output each cycle with a bench model. This catches ordering errors or stale pulses after long write queues.

// File: rtl/mem_req_frontend.sv
module mem_req_frontend #(
  parameter int ADDR_W    = 24,
  parameter int CS_W      = 2,
  parameter int SIZE_W    = 3,
  parameter int DATA_W    = 32,
  parameter int DEV_BL    = 8,
  parameter bit DDR2_MODE = 1'b0,
  parameter int DEPTH     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CS_W-1:0]     req_cs,
  input  logic [SIZE_W-1:0]   req_size,
  output logic                req_ready,
  output logic                req_err,
  output logic                wdata_req,
  input  logic [DATA_W-1:0]   wdata_in,
  input  logic [DATA_W/8-1:0] wbe_in,
  output logic                wd_valid,
  output logic [DATA_W-1:0]   wd_data,
  output logic [DATA_W/8-1:0] wd_be,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic                cmd_write,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [CS_W-1:0]     cmd_cs,
  output logic [SIZE_W-1:0]   cmd_size
);
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int HALF_BL  = DEV_BL / 2;
  localparam int MAX_SIZE = DDR2_MODE ? ((HALF_BL < 2) ? HALF_BL : 2) : HALF_BL;
  localparam int ENT_W    = 1 + ADDR_W + CS_W + SIZE_W;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [ENT_W-1:0]  cq [DEPTH];
  logic [PTR_W-1:0]  c_wr, c_rd;
  logic [CNT_W-1:0]  c_cnt;
  logic [SIZE_W-1:0] wq [DEPTH];
  logic [PTR_W-1:0]  w_wr, w_rd;
  logic [CNT_W-1:0]  w_cnt;
  logic [SIZE_W-1:0] beat;
  logic size_ok, acc, pop, wpush, wlast;

  assign size_ok   = (req_size != '0) && (req_size <= SIZE_W'(MAX_SIZE));
  assign req_ready = (c_cnt != CNT_W'(DEPTH)) && (w_cnt != CNT_W'(DEPTH));
  assign req_err   = req_valid && req_ready && !size_ok;
  assign acc       = req_valid && req_ready && size_ok;
  assign wpush     = acc && req_write;

  assign cmd_valid = (c_cnt != '0);
  assign pop       = cmd_valid && cmd_ready;
  assign {cmd_write, cmd_addr, cmd_cs, cmd_size} = cq[c_rd];

  assign wdata_req = (w_cnt != '0);
  assign wlast     = wdata_req && (beat + 1'b1 == wq[w_rd]);
  assign wd_data   = wdata_in;
  assign wd_be     = wbe_in;

  always_ff @(posedge clk) begin
    if (acc) cq[c_wr] <= {req_write, req_addr, req_cs, req_size};
    if (wpush) wq[w_wr] <= req_size;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_wr  <= '0;
      c_rd  <= '0;
      c_cnt <= '0;
    end else begin
      if (acc) c_wr <= bump(c_wr);
      if (pop) c_rd <= bump(c_rd);
      case ({acc, pop})
        2'b10:   c_cnt <= c_cnt + 1'b1;
        2'b01:   c_cnt <= c_cnt - 1'b1;
        default: c_cnt <= c_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_wr     <= '0;
      w_rd     <= '0;
      w_cnt    <= '0;
      beat     <= '0;
      wd_valid <= 1'b0;
    end else begin
      wd_valid <= wdata_req;
      if (wpush) w_wr <= bump(w_wr);
      if (wlast) begin
        w_rd <= bump(w_rd);
        beat <= '0;
      end else if (wdata_req) begin
        beat <= beat + 1'b1;
      end
      case ({wpush, wlast})
        2'b10:   w_cnt <= w_cnt + 1'b1;
        2'b01:   w_cnt <= w_cnt - 1'b1;
        default: w_cnt <= w_cnt;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (c_cnt <= CNT_W'(DEPTH)) && (w_cnt <= CNT_W'(DEPTH)));

  a_r4_full_not_ready: assert property (@(posedge clk) disable iff (rst)
    (c_cnt == CNT_W'(DEPTH)) |-> !req_ready);

  a_r2_head_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_write, cmd_addr, cmd_cs, cmd_size})));

  a_r6_err_not_queued: assert property (@(posedge clk) disable iff (rst)
    req_err |=> (c_cnt <= $past(c_cnt)));

  a_r7_write_asks_data: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_err && req_write) |=> wdata_req);

  a_r8_data_strobe: assert property (@(posedge clk) disable iff (rst)
    wdata_req |=> wd_valid);

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !cmd_valid && !wdata_req && !wd_valid));
endmodule

// File: tb/sim_mem_req_frontend.sv
`timescale 1ns/1ps
module sim_mem_req_frontend;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, req_valid, req_write, cmd_ready;
  logic [23:0] req_addr;
  logic [1:0]  req_cs;
  logic [2:0]  req_size;
  logic [31:0] wdata_in;
  logic [3:0]  wbe_in;
  logic req_ready, req_err, wdata_req, wd_valid, cmd_valid, cmd_write;
  logic [31:0] wd_data;
  logic [3:0]  wd_be;
  logic [23:0] cmd_addr;
  logic [1:0]  cmd_cs;
  logic [2:0]  cmd_size;
  logic u1_ready, u1_err, u1_wreq, u1_wdv, u1_cv, u1_cw;
  logic [31:0] u1_wd;
  logic [3:0]  u1_be;
  logic [23:0] u1_ca;
  logic [1:0]  u1_cc;
  logic [2:0]  u1_cs;

  mem_req_frontend u0 (
    .clk, .rst, .req_valid, .req_write, .req_addr, .req_cs, .req_size,
    .req_ready, .req_err, .wdata_req, .wdata_in, .wbe_in, .wd_valid,
    .wd_data, .wd_be, .cmd_valid, .cmd_ready, .cmd_write, .cmd_addr,
    .cmd_cs, .cmd_size);

  mem_req_frontend #(.DDR2_MODE(1'b1)) u1 (
    .clk, .rst, .req_valid, .req_write, .req_addr, .req_cs, .req_size,
    .req_ready(u1_ready), .req_err(u1_err), .wdata_req(u1_wreq),
    .wdata_in, .wbe_in, .wd_valid(u1_wdv), .wd_data(u1_wd), .wd_be(u1_be),
    .cmd_valid(u1_cv), .cmd_ready(1'b1), .cmd_write(u1_cw), .cmd_addr(u1_ca),
    .cmd_cs(u1_cc), .cmd_size(u1_cs));

  int total = 0, fails = 0, cycles = 0;
  logic [29:0] m_q[$];
  logic [2:0]  m_wq[$];
  int m_beat = 0;
  logic m_wdv = 1'b0;
  logic o_ready, o_err, o_wreq, o_cv;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit legal(input logic [2:0] s, input bit ddr2);
    return (s != 0) && (s <= (ddr2 ? 3'd2 : 3'd4));
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic step(input logic rs, input logic v, input logic w, input logic [23:0] a,
                      input logic [1:0] c, input logic [2:0] s, input logic cr);
    bit e_ready, e_err, e_acc, e_wreq, e_cv;
    @(negedge clk);
    rst = rs; req_valid = v; req_write = w; req_addr = a; req_cs = c; req_size = s;
    cmd_ready = cr; wdata_in = $urandom; wbe_in = 4'($urandom);
    #1;
    e_ready = (m_q.size() < 4) && (m_wq.size() < 4);
    e_err   = v && e_ready && !legal(s, 0);
    e_acc   = v && e_ready && legal(s, 0);
    e_wreq  = m_wq.size() != 0;
    e_cv    = m_q.size() != 0;
    check(req_ready == e_ready, "R4 req_ready", req_ready, e_ready);
    check(req_err == e_err, "R6 req_err", req_err, e_err);
    check(cmd_valid == e_cv, "R2 cmd_valid", cmd_valid, e_cv);
    if (e_cv)
      check({cmd_write, cmd_addr, cmd_cs, cmd_size} == m_q[0], "R1 cmd fields",
            {cmd_write, cmd_addr, cmd_cs, cmd_size}, m_q[0]);
    check(wdata_req == e_wreq, "R7 wdata_req", wdata_req, e_wreq);
    check(wd_valid == m_wdv, "R8 wd_valid", wd_valid, m_wdv);
    if (m_wdv)
      check({wd_data, wd_be} == {wdata_in, wbe_in}, "R8 wd_data", {wd_data, wd_be}, {wdata_in, wbe_in});
    o_ready = req_ready; o_err = req_err; o_wreq = wdata_req; o_cv = cmd_valid;
    @(posedge clk);
    if (rs) begin
      m_q.delete(); m_wq.delete(); m_beat = 0; m_wdv = 1'b0;
    end else begin
      if (e_cv && cr) void'(m_q.pop_front());
      if (e_wreq) begin
        if (m_beat + 1 == int'(m_wq[0])) begin
          void'(m_wq.pop_front()); m_beat = 0;
        end else m_beat++;
      end
      if (e_acc) m_q.push_back({w, a, c, s});
      if (e_acc && w) m_wq.push_back(s);
      m_wdv = e_wreq;
    end
  endtask

  task automatic idle(input logic cr);
    step(1'b0, 1'b0, 1'b0, 24'h0, 2'd0, 3'd1, cr);
  endtask

  initial begin
    int pulses;
    bit hold;
    logic v, w, cr;
    logic [23:0] a;
    logic [1:0] c;
    logic [2:0] s;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; req_valid = 0; req_write = 0; req_addr = 0; req_cs = 0;
    req_size = 1; cmd_ready = 0; wdata_in = 0; wbe_in = 0;
    step(1'b1, 0, 0, 0, 0, 1, 0);
    step(1'b1, 0, 0, 0, 0, 1, 0);
    idle(1'b0);
    check(o_ready && !o_cv && !o_wreq && !wd_valid, "R10 reset state", {o_ready, o_cv, o_wreq}, 3'b100);

    for (int sz = 0; sz < 8; sz++) begin
      step(1'b0, 1'b1, 1'b0, 24'h100 + 24'(sz), 2'd1, 3'(sz), 1'b1);
      check(u1_err == !legal(3'(sz), 1), "R5 ddr2 size limit", u1_err, !legal(3'(sz), 1));
      check(o_err == !legal(3'(sz), 0), "R5 normal size limit", o_err, !legal(3'(sz), 0));
    end
    for (int k = 0; k < 3; k++) idle(1'b1);
    check(!o_cv, "R6 illegal sizes not queued", o_cv, 0);

    for (int k = 0; k < 4; k++)
      step(1'b0, 1'b1, 1'b0, 24'h2000 + 24'(k), 2'(k), 3'(k + 1), 1'b0);
    step(1'b0, 1'b1, 1'b0, 24'h2abc, 2'd2, 3'd1, 1'b0);
    check(!o_ready, "R3 fifth request refused", o_ready, 0);
    step(1'b0, 1'b1, 1'b0, 24'h2abc, 2'd2, 3'd1, 1'b1);
    check(!o_ready, "R4 ready low in drain cycle", o_ready, 0);
    step(1'b0, 1'b1, 1'b0, 24'h2abc, 2'd2, 3'd1, 1'b0);
    check(o_ready, "R4 ready back after drain", o_ready, 1);
    for (int k = 0; k < 6; k++) idle(1'b1);

    step(1'b0, 1'b1, 1'b0, 24'h3000, 2'd0, 3'd4, 1'b1);
    pulses = 0;
    for (int k = 0; k < 5; k++) begin idle(1'b1); pulses += int'(o_wreq); end
    check(pulses == 0, "R9 read makes no data pulse", pulses, 0);

    step(1'b0, 1'b1, 1'b1, 24'h4000, 2'd3, 3'd2, 1'b1);
    step(1'b0, 1'b1, 1'b1, 24'h4002, 2'd3, 3'd3, 1'b1);
    pulses = int'(o_wreq);
    for (int k = 0; k < 8; k++) begin idle(1'b1); pulses += int'(o_wreq); end
    check(pulses == 5, "R7 back-to-back pulse count", pulses, 5);

    step(1'b0, 1'b1, 1'b1, 24'h5000, 2'd0, 3'd4, 1'b0);
    idle(1'b0);
    step(1'b1, 0, 0, 0, 0, 1, 0);
    idle(1'b0);
    check(!o_wreq && !o_cv && o_ready, "R10 reset cancels pulses", {o_wreq, o_cv, o_ready}, 3'b001);

    hold = 0; v = 0; w = 0; a = 0; c = 0; s = 1;
    for (int k = 0; k < 4000; k++) begin
      if (!hold) begin
        v = ($urandom % 3) != 0;
        w = $urandom % 2;
        a = 24'($urandom);
        c = 2'($urandom);
        s = (($urandom % 10) == 0) ? 3'($urandom) : 3'(1 + $urandom % 4);
      end
      cr = ($urandom % 4) != 0;
      step((($urandom % 500) == 0), v, w, a, c, s, cr);
      hold = v && !o_ready;
    end
    finish_run();
  end
endmodule